// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block sits behind a byte receiver and turns a stream of command frames into register accesses. A frame opens with a fixed five-byte header: 0x40, 0x4C, 0x44, 0x53, 0x7E. It closes with a single 0x7E byte. Between the header and the closing byte lies a run of 16-bit command words of any length. Each word carries a 4-bit register address and an 8-bit value. The value bits are spread across the word, and two extra bits must be the inverted copies of value bits 5 and 7.

A word that passes this check becomes a one-cycle write strobe carrying its address and data. Two addresses, set by parameters, are reserved for reads. A valid word aimed at either of them returns the current status byte on a separate one-cycle output and produces no write. A word that fails the check raises a one-cycle error pulse and is dropped.

Bytes arrive one per asserted `rx_valid`, with any number of idle cycles between them. The closing byte is recognised only where the next word would begin. This matters because 0x7E can also appear as the low byte of a word.

Top module: `cmd_frame_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `wr_en`, `rd_valid`, `word_err` and `frame_end` are low and the decoder is hunting for a header.
- R2: Bytes received while no header has been matched produce no output at all.
- R3: The header must arrive as 0x40, 0x4C, 0x44, 0x53, 0x7E. A wrong byte restarts the hunt. If the wrong byte is itself 0x40, it counts as the first header byte.
- R4: Each word is sent high byte first. Word bits [11:8] give the address. Word bits [13:12] give value bits [7:6], and word bits [5:0] give value bits [5:0]. A valid write appears on `wr_en`, `wr_addr` and `wr_data` in the cycle after its low byte is accepted.
- R5: A word is valid only if word bit 6 equals the inverse of value bit 5 and word bit 14 equals the inverse of value bit 7. If either check fails, `word_err` pulses for one cycle after the low byte and no write or read result appears.
- R6: Word bits 7 and 15 have no effect on the decoded result.
- R7: A 0x7E byte in the high-byte position ends the frame and pulses `frame_end` one cycle later. Bytes that follow it are ignored until a new header arrives.
- R8: A 0x7E byte in the low-byte position is word data, not a terminator. Later words in the same frame still decode.
- R9: A valid word addressed to `RD_ADDR_A` (default 14) or `RD_ADDR_B` (default 15) pulses `rd_valid` one cycle after its low byte. `rd_byte` then holds the value of `status_in` from the cycle the low byte was accepted. No write is issued for such a word.
- R10: A frame may hold any number of words, including runs of 18 or more. Each word is decoded in order.
- R11: Cycles with `rx_valid` low have no effect, whatever `rx_byte` holds.
- R12: At most one of `wr_en`, `rd_valid`, `word_err` and `frame_end` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | `rx_byte` holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| status_in | input | 8 | Status byte returned for reads |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Write address, valid with `wr_en` |
| wr_data | output | 8 | Write value, valid with `wr_en` |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_byte | output | 8 | Status byte, valid with `rd_valid` |
| word_err | output | 1 | One-cycle pulse for a word that failed the check |
| frame_end | output | 1 | One-cycle pulse when a frame terminator is accepted |

## Verification
Every result of this block is due exactly one cycle after the byte that completes it: the low byte of a word, or a terminator in the high-byte position. Nothing arrives earlier or later. The bench keeps a monitor that samples all four strobes on every falling edge and logs each pulse in order. This log is compared, event for event, with a queue of expected events that the bench builds as it sends bytes. A pulse that arrives a cycle late still lines up. A missing pulse, an extra one, or one carrying wrong contents is reported. Idle cycles filled with random bytes separate the received bytes, so results must not depend on adjacent cycles.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

   localparam int PRE_LEN = 5;
   localparam int WORD_W  = 16;
   localparam int ADDR_W  = 4;
   localparam int DATA_W  = 8;
   localparam int BYTE_W  = 8;

   typedef enum logic [1:0] {
      FR_HUNT = 2'd0,
      FR_HI   = 2'd1,
      FR_LO   = 2'd2
   } fr_state_t;

   // header byte for a given position
   function automatic logic [BYTE_W-1:0] pre_byte(input int unsigned pos);
      case (pos)
         0:       pre_byte = 8'h40;
         1:       pre_byte = 8'h4C;
         2:       pre_byte = 8'h44;
         3:       pre_byte = 8'h53;
         default: pre_byte = 8'h7E;
      endcase
   endfunction

endpackage

// File: rtl/cfd_preamble.sv
module cfd_preamble #(
   parameter int LEN = cfd_pkg::PRE_LEN
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       step,
   input  logic [cfd_pkg::BYTE_W-1:0] din,
   output logic                       found
);
   localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

   if (LEN < 2 || LEN > cfd_pkg::PRE_LEN) begin : g_len_bad
      $error("cfd_preamble: LEN out of range");
   end

   logic [IDX_W-1:0] idx;
   logic [LEN-1:0]   hit;
   logic             cur_hit;

   for (genvar i = 0; i < LEN; i++) begin : g_hit
      assign hit[i] = (din == cfd_pkg::pre_byte(i));
   end

   assign cur_hit = hit[idx];
   assign found   = step && cur_hit && (idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (step) begin
         if (cur_hit)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
         else
            idx <= hit[0] ? IDX_W'(1) : '0;
      end
   end

endmodule

// File: rtl/cfd_framer.sv
module cfd_framer #(
   parameter logic [7:0] TERM = 8'h7E
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  din,
   input  logic        pre_found,
   output logic        hunting,
   output logic        word_valid,
   output logic [15:0] word,
   output logic        term_seen
);
   import cfd_pkg::*;

   fr_state_t  state;
   logic [7:0] hi_q;

   assign hunting    = (state == FR_HUNT);
   assign term_seen  = in_valid && (state == FR_HI) && (din == TERM);
   assign word_valid = in_valid && (state == FR_LO);
   assign word       = {hi_q, din};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= FR_HUNT;
         hi_q  <= '0;
      end else if (in_valid) begin
         case (state)
            FR_HUNT: if (pre_found) state <= FR_HI;
            FR_HI: begin
               if (din == TERM) begin
                  state <= FR_HUNT;
               end else begin
                  hi_q  <= din;
                  state <= FR_LO;
               end
            end
            FR_LO:   state <= FR_HI;
            default: state <= FR_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/cfd_word_decode.sv
module cfd_word_decode (
   input  logic [15:0] word,
   output logic [3:0]  addr,
   output logic [7:0]  value,
   output logic        ok
);
   logic unused_bits;

   assign value       = {word[13:12], word[5:0]};
   assign addr        = word[11:8];
   assign ok          = (word[6] ^ word[5]) & (word[14] ^ word[13]);
   assign unused_bits = word[15] ^ word[7];

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
   parameter logic [7:0] TERM_BYTE = 8'h7E,
   parameter logic [3:0] RD_ADDR_A = 4'd14,
   parameter logic [3:0] RD_ADDR_B = 4'd15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic [7:0] status_in,
   output logic       wr_en,
   output logic [3:0] wr_addr,
   output logic [7:0] wr_data,
   output logic       rd_valid,
   output logic [7:0] rd_byte,
   output logic       word_err,
   output logic       frame_end
);
   localparam int N_RD = 2;
   localparam logic [N_RD-1:0][3:0] RD_SET = {RD_ADDR_B, RD_ADDR_A};

   if (RD_ADDR_A == RD_ADDR_B) begin : g_rd_bad
      $error("cmd_frame_decoder: read addresses must differ");
   end
   if (TERM_BYTE != cfd_pkg::pre_byte(cfd_pkg::PRE_LEN - 1)) begin : g_term_bad
      $error("cmd_frame_decoder: terminator must equal last header byte");
   end

   logic        hunting, pre_found, word_valid, term_seen, dec_ok;
   logic [15:0] word;
   logic [3:0]  dec_addr;
   logic [7:0]  dec_value;
   logic [N_RD-1:0] rd_hit;
   logic        rd_match;

   cfd_preamble #(.LEN(cfd_pkg::PRE_LEN)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (rx_valid && hunting),
      .din   (rx_byte),
      .found (pre_found)
   );

   cfd_framer #(.TERM(TERM_BYTE)) u_frm (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (rx_valid),
      .din        (rx_byte),
      .pre_found  (pre_found),
      .hunting    (hunting),
      .word_valid (word_valid),
      .word       (word),
      .term_seen  (term_seen)
   );

   cfd_word_decode u_dec (
      .word  (word),
      .addr  (dec_addr),
      .value (dec_value),
      .ok    (dec_ok)
   );

   for (genvar i = 0; i < N_RD; i++) begin : g_rd
      assign rd_hit[i] = (dec_addr == RD_SET[i]);
   end
   assign rd_match = |rd_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         rd_valid  <= 1'b0;
         rd_byte   <= '0;
         word_err  <= 1'b0;
         frame_end <= 1'b0;
      end else begin
         wr_en     <= 1'b0;
         rd_valid  <= 1'b0;
         word_err  <= 1'b0;
         frame_end <= term_seen;
         if (word_valid) begin
            if (!dec_ok) begin
               word_err <= 1'b1;
            end else if (rd_match) begin
               rd_valid <= 1'b1;
               rd_byte  <= status_in;
            end else begin
               wr_en   <= 1'b1;
               wr_addr <= dec_addr;
               wr_data <= dec_value;
            end
         end
      end
   end

endmodule

// File: rtl/cfd_checker.sv
module cfd_checker #(
   parameter logic [7:0] TERM_BYTE = 8'h7E,
   parameter logic [3:0] RD_ADDR_A = 4'd14,
   parameter logic [3:0] RD_ADDR_B = 4'd15
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic [7:0] rx_byte,
   input logic       wr_en,
   input logic [3:0] wr_addr,
   input logic [7:0] wr_data,
   input logic       rd_valid,
   input logic       word_err,
   input logic       frame_end
);
   AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, rd_valid, word_err, frame_end})); // R12

   AST_RESULT_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || rd_valid || word_err || frame_end) |-> $past(rx_valid)); // R11

   AST_WR_LOW_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_data[5:0] == $past(rx_byte[5:0]))); // R4

   AST_WR_CHECK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(rx_byte[6]) != $past(rx_byte[5]))); // R5

   AST_WR_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr != RD_ADDR_A && wr_addr != RD_ADDR_B)); // R9

   AST_END_ON_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> ($past(rx_byte) == TERM_BYTE)); // R7

endmodule

bind cmd_frame_decoder cfd_checker #(
   .TERM_BYTE (TERM_BYTE),
   .RD_ADDR_A (RD_ADDR_A),
   .RD_ADDR_B (RD_ADDR_B)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_byte   (rx_byte),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_valid  (rd_valid),
   .word_err  (word_err),
   .frame_end (frame_end)
);

// File: tb/sim_cmd_frame_decoder.sv
module sim_cmd_frame_decoder;
   localparam logic [3:0] RDA = 4'd14;
   localparam logic [3:0] RDB = 4'd15;
   localparam int K_WR = 1, K_RD = 2, K_ERR = 3, K_END = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [7:0] status_in = 8'h00;
   logic       wr_en, rd_valid, word_err, frame_end;
   logic [3:0] wr_addr;
   logic [7:0] wr_data, rd_byte;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int    exp_kind[$];
   int    exp_addr[$];
   int    exp_data[$];
   string exp_tag[$];
   int    obs_kind[$];
   int    obs_addr[$];
   int    obs_data[$];

   always #5 clk = ~clk;

   cmd_frame_decoder #(.RD_ADDR_A(RDA), .RD_ADDR_B(RDB)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .status_in(status_in), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_byte(rd_byte),
      .word_err(word_err), .frame_end(frame_end)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en)     begin obs_kind.push_back(K_WR);  obs_addr.push_back(int'(wr_addr)); obs_data.push_back(int'(wr_data)); end
         if (rd_valid)  begin obs_kind.push_back(K_RD);  obs_addr.push_back(0); obs_data.push_back(int'(rd_byte)); end
         if (word_err)  begin obs_kind.push_back(K_ERR); obs_addr.push_back(0); obs_data.push_back(0); end
         if (frame_end) begin obs_kind.push_back(K_END); obs_addr.push_back(0); obs_data.push_back(0); end
      end
   end

   function automatic logic [15:0] make_word(input logic [3:0] a, input logic [7:0] v,
                                             input bit flip5, input bit flip7,
                                             input bit j7, input bit j15);
      make_word = {j15, ~v[7] ^ flip7, v[7:6], a, j7, ~v[5] ^ flip5, v[5:0]};
   endfunction

   task automatic expect_ev(input int k, input int a, input int d, input string tag);
      exp_kind.push_back(k); exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(tag);
   endtask

   // expected outcome of one word, from the field layout and check rule
   task automatic expect_word(input logic [15:0] w, input string tag);
      logic [7:0] v;
      logic [3:0] a;
      bit good;
      v = {w[13:12], w[5:0]};
      a = w[11:8];
      good = (w[6] == ~w[5]) && (w[14] == ~w[13]);
      if (!good) expect_ev(K_ERR, 0, 0, tag);
      else if (a == RDA || a == RDB) expect_ev(K_RD, 0, int'(status_in), tag);
      else expect_ev(K_WR, int'(a), int'(v), tag);
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_byte  = 8'($urandom);
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   task automatic put_word(input logic [15:0] w);
      put(w[15:8]);
      put(w[7:0]);
   endtask

   task automatic header();
      put(8'h40); put(8'h4C); put(8'h44); put(8'h53); put(8'h7E);
   endtask

   task automatic check_events(input string extra_tag);
      repeat (3) @(negedge clk);
      while (exp_kind.size() > 0) begin
         int k, a, d;
         string t;
         k = exp_kind.pop_front(); a = exp_addr.pop_front();
         d = exp_data.pop_front(); t = exp_tag.pop_front();
         total++;
         if (obs_kind.size() == 0) begin
            bad++;
            $display("FAIL %s: actual no event, expected kind=%0d addr=%0d data=%0h", t, k, a, d);
         end else begin
            int ok, oa, od;
            ok = obs_kind.pop_front(); oa = obs_addr.pop_front(); od = obs_data.pop_front();
            if (ok != k || (k == K_WR && (oa != a || od != d)) || (k == K_RD && od != d)) begin
               bad++;
               $display("FAIL %s: actual kind=%0d addr=%0d data=%0h, expected kind=%0d addr=%0d data=%0h",
                        t, ok, oa, od, k, a, d);
            end
         end
      end
      total++;
      if (obs_kind.size() != 0) begin
         bad++;
         $display("FAIL %s: actual %0d extra events (first kind=%0d), expected 0",
                  extra_tag, obs_kind.size(), obs_kind[0]);
         obs_kind.delete(); obs_addr.delete(); obs_data.delete();
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual timeout, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] w;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      // R1: quiet in reset
      total++;
      if (wr_en || rd_valid || word_err || frame_end) begin
         bad++;
         $display("FAIL R1: actual strobes=%b, expected 0000", {wr_en, rd_valid, word_err, frame_end});
      end
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (wr_en || rd_valid || word_err || frame_end) begin
         bad++;
         $display("FAIL R1: actual strobes=%b after reset, expected 0000", {wr_en, rd_valid, word_err, frame_end});
      end

      // R2: words with no header produce nothing
      put_word(make_word(4'd3, 8'h12, 0, 0, 0, 0));
      put_word(make_word(4'd5, 8'h9A, 0, 0, 0, 0));
      put(8'h7E);
      check_events("R2");

      // R4, R6, R8, R7: fields, ignored bits, low-byte 0x7E, terminator
      status_in = 8'hC3;
      header();
      w = make_word(4'd3, 8'hA5, 0, 0, 0, 0); put_word(w); expect_ev(K_WR, 3, 8'hA5, "R4");
      w = make_word(4'd9, 8'h3C, 0, 0, 1, 1); put_word(w); expect_ev(K_WR, 9, 8'h3C, "R6");
      w = make_word(4'd2, 8'h40, 0, 0, 1, 1); put_word(w); expect_ev(K_WR, 2, 8'h40, "R6");
      put_word(16'h0A7E); expect_ev(K_ERR, 0, 0, "R8");
      w = make_word(4'd5, 8'hFF, 0, 0, 0, 0); put_word(w); expect_ev(K_WR, 5, 8'hFF, "R8");
      put(8'h7E); expect_ev(K_END, 0, 0, "R7");
      put_word(make_word(4'd2, 8'h11, 0, 0, 0, 0));
      check_events("R7");

      // R5: check bits
      header();
      put_word(make_word(4'd4, 8'h20, 1, 0, 0, 0)); expect_ev(K_ERR, 0, 0, "R5");
      put_word(make_word(4'd4, 8'h80, 0, 1, 0, 0)); expect_ev(K_ERR, 0, 0, "R5");
      put_word(make_word(4'd4, 8'hA0, 1, 1, 0, 0)); expect_ev(K_ERR, 0, 0, "R5");
      put_word(make_word(4'd4, 8'hA0, 0, 0, 0, 0)); expect_ev(K_WR, 4, 8'hA0, "R5");
      put(8'h7E); expect_ev(K_END, 0, 0, "R5");
      check_events("R5");

      // R9: read addresses
      status_in = 8'h5A;
      header();
      put_word(make_word(RDA, 8'h00, 0, 0, 0, 0)); expect_ev(K_RD, 0, 8'h5A, "R9");
      put_word(make_word(RDB, 8'h77, 0, 0, 0, 0)); expect_ev(K_RD, 0, 8'h5A, "R9");
      put_word(make_word(RDB, 8'h77, 1, 0, 0, 0)); expect_ev(K_ERR, 0, 0, "R9");
      put(8'h7E); expect_ev(K_END, 0, 0, "R9");
      check_events("R9");

      // R3: broken header, restart on 0x40
      put(8'h40); put(8'h4C); put(8'h99);
      put_word(make_word(4'd1, 8'h22, 0, 0, 0, 0));
      put(8'h40); put(8'h4C); put(8'h40);
      put(8'h4C); put(8'h44); put(8'h53); put(8'h7E);
      put_word(make_word(4'd6, 8'h81, 0, 0, 0, 0)); expect_ev(K_WR, 6, 8'h81, "R3");
      put(8'h7E); expect_ev(K_END, 0, 0, "R3");
      check_events("R3");

      // R10, R11: long random frames with idle garbage
      for (int f = 0; f < 6; f++) begin
         int n;
         n = 18 + int'($urandom_range(0, 12));
         status_in = 8'($urandom);
         header();
         for (int i = 0; i < n; i++) begin
            w = make_word(4'($urandom), 8'($urandom),
                          ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
                          1'($urandom), 1'($urandom));
            if (w[15:8] == 8'h7E) w[15] = 1'b1;
            put_word(w);
            expect_word(w, (i % 2 == 0) ? "R10" : "R11");
         end
         put(8'h7E); expect_ev(K_END, 0, 0, "R10");
         check_events("R11");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule